// File: doc/BRIEF.md
# Task-Switch Segment Descriptor Validator

When a task switch loads the segment registers of the incoming task, each selector taken from the saved task image needs a matching descriptor, and that descriptor must pass rules that depend on which register it is for. This block checks one selector and its 8-byte descriptor per request. A role input chooses the rule set: stack register, code register, or one of the data registers. Besides the selector and the two descriptor words, the block takes a flag saying whether the descriptor fetch succeeded and the requested privilege level (RPL) of the incoming code selector.

One clock after a request, the block gives a registered verdict. The verdict is one of: load the descriptor into the register's cache; accept a null selector and leave the cache invalid; raise an invalid-task-state fault; raise a not-present fault; or raise a stack fault. It also gives the error code for a fault and the 64-bit descriptor that is to be loaded. Fetching the descriptor from memory is done elsewhere.

Top module: `segdesc_validator`

## Requirements
- R1: A request (`chk_valid`=1 at a rising edge) produces `res_valid`=1 with its verdict on the next edge. A cycle without a request gives `res_valid`=0 and leaves `verdict`, `err_code` and `cache_desc` unchanged. Reset clears all four outputs to zero.
- R2: A selector is null when bits 15:2 are all zero. A null selector with `role[1]`=1 (data roles 2 and 3) gives verdict 1 (null, cache invalid). A null selector with role 0 (stack) or role 1 (code) gives verdict 2 (invalid-task-state fault). The null test comes before every other check.
- R3: A non-null selector with `fetch_ok`=0 gives verdict 2.
- R4: The descriptor fields are read from the high word: type = bits 11:8, S = bit 12, DPL = bits 14:13, P = bit 15. In the stack role the segment must have S=1, type bit 3 = 0 (data) and type bit 1 = 1 (writable). Otherwise the verdict is 2.
- R5: In the stack role the DPL must equal both `code_rpl` and the selector RPL (bits 1:0); otherwise the verdict is 2. A stack segment that passes these checks but has P=0 gives verdict 4 (stack fault).
- R6: In the code role the segment must have S=1 and type bit 3 = 1. When type bit 2 = 0 (non-conforming), DPL must equal the selector RPL. When type bit 2 = 1 (conforming), DPL must be less than or equal to the selector RPL. Any failure gives verdict 2.
- R7: In a data role the segment must have S=1 and be either data (type bit 3 = 0) or readable code (type bits 3 and 1 both 1). Otherwise the verdict is 2.
- R8: In a data role, a data segment or a non-conforming code segment gives verdict 2 if the selector RPL or `code_rpl` is greater than DPL. Conforming code has no privilege check in this role.
- R9: A code-role or data-role descriptor that passes every other check but has P=0 gives verdict 3 (not-present fault).
- R10: The checks run in a fixed order: null, fetch, type, privilege, presence. Only the first failure is reported. A descriptor that passes all checks gives verdict 0 (load).
- R11: For verdicts 2, 3 and 4, `err_code` is the selector with bits 1:0 cleared. For verdicts 0 and 1 it is zero.
- R12: For verdict 0, `cache_desc` is {`desc_hi`, `desc_lo`}. For any other verdict it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Request strobe |
| role | input | 2 | 0 stack, 1 code, 2 or 3 data register |
| sel | input | 16 | Raw selector |
| desc_lo | input | 32 | Descriptor low word |
| desc_hi | input | 32 | Descriptor high word |
| fetch_ok | input | 1 | Descriptor fetch succeeded |
| code_rpl | input | 2 | RPL of the incoming code selector |
| res_valid | output | 1 | Verdict valid |
| verdict | output | 3 | 0 load, 1 null, 2 invalid-task-state fault, 3 not-present fault, 4 stack fault |
| err_code | output | 16 | Fault error code |
| cache_desc | output | 64 | Descriptor to load into the cache |

## Verification
The hardest cases to reach are the ones where several checks fail at once. For example, a stack descriptor that is writable data, has a DPL that matches only one of the two RPLs, and is also not present. These cases show whether the fault order is right. The bench reaches them by sweeping every combination of role, the two RPLs, fetch status, null and non-null selector, and all 256 values of descriptor high-word bits 15:8. It compares each verdict with a model written from the requirements.

// File: rtl/segdesc_validator.sv
module segdesc_validator (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_valid,
  input  logic [1:0]  role,
  input  logic [15:0] sel,
  input  logic [31:0] desc_lo,
  input  logic [31:0] desc_hi,
  input  logic        fetch_ok,
  input  logic [1:0]  code_rpl,
  output logic        res_valid,
  output logic [2:0]  verdict,
  output logic [15:0] err_code,
  output logic [63:0] cache_desc
);
  localparam logic [2:0] V_LOAD = 3'd0;
  localparam logic [2:0] V_NULL = 3'd1;
  localparam logic [2:0] V_TS   = 3'd2;
  localparam logic [2:0] V_NP   = 3'd3;
  localparam logic [2:0] V_SS   = 3'd4;

  logic [3:0] typ;
  logic       s_bit, p_bit;
  logic [1:0] dpl, rpl;
  logic       is_null, is_code, conf, rd_wr;
  logic       type_ok, priv_ok;
  logic [2:0] v_next;

  assign typ     = desc_hi[11:8];
  assign s_bit   = desc_hi[12];
  assign dpl     = desc_hi[14:13];
  assign p_bit   = desc_hi[15];
  assign rpl     = sel[1:0];
  assign is_null = (sel[15:2] == 14'd0);
  assign is_code = typ[3];
  assign conf    = typ[2];
  assign rd_wr   = typ[1];

  always_comb begin
    type_ok = 1'b0;
    priv_ok = 1'b0;
    if (role[1]) begin
      type_ok = s_bit && (!is_code || rd_wr);
      priv_ok = (is_code && conf) || ((rpl <= dpl) && (code_rpl <= dpl));
    end else if (role[0]) begin
      type_ok = s_bit && is_code;
      priv_ok = conf ? (dpl <= rpl) : (dpl == rpl);
    end else begin
      type_ok = s_bit && !is_code && rd_wr;
      priv_ok = (dpl == code_rpl) && (dpl == rpl);
    end
  end

  always_comb begin
    if (is_null)        v_next = role[1] ? V_NULL : V_TS;
    else if (!fetch_ok) v_next = V_TS;
    else if (!type_ok)  v_next = V_TS;
    else if (!priv_ok)  v_next = V_TS;
    else if (!p_bit)    v_next = (role == 2'd0) ? V_SS : V_NP;
    else                v_next = V_LOAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      verdict    <= V_LOAD;
      err_code   <= 16'd0;
      cache_desc <= 64'd0;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid) begin
        verdict    <= v_next;
        err_code   <= (v_next >= V_TS) ? {sel[15:2], 2'b00} : 16'd0;
        cache_desc <= (v_next == V_LOAD) ? {desc_hi, desc_lo} : 64'd0;
      end
    end
  end
endmodule

// File: rtl/segdesc_validator_chk.sv
module segdesc_validator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chk_valid,
  input logic [1:0]  role,
  input logic [15:0] sel,
  input logic        fetch_ok,
  input logic        res_valid,
  input logic [2:0]  verdict,
  input logic [15:0] err_code,
  input logic [63:0] cache_desc
);
  a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(chk_valid));

  a_r2_null_data_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && sel[15:2] == 14'd0 && role[1]) |=> (verdict == 3'd1));

  a_r3_fetch_fail_ts: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && sel[15:2] != 14'd0 && !fetch_ok) |=> (verdict == 3'd2));

  a_r5_stack_fault_only_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && role != 2'd0) |=> (verdict != 3'd4));

  a_r11_err_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (err_code[1:0] == 2'b00));

  a_r12_no_cache_unless_load: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && verdict != 3'd0) |-> (cache_desc == 64'd0));

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_valid && $past(rst_n)) |=> ($stable(verdict) && $stable(err_code)));
endmodule

bind segdesc_validator segdesc_validator_chk chk_i (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .role(role), .sel(sel),
  .fetch_ok(fetch_ok), .res_valid(res_valid), .verdict(verdict),
  .err_code(err_code), .cache_desc(cache_desc)
);

// File: tb/segdesc_validator_tb.sv
module segdesc_validator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic [1:0]  role = 2'd0;
  logic [15:0] sel = 16'd0;
  logic [31:0] desc_lo = 32'd0;
  logic [31:0] desc_hi = 32'd0;
  logic        fetch_ok = 1'b0;
  logic [1:0]  code_rpl = 2'd0;
  logic        res_valid;
  logic [2:0]  verdict;
  logic [15:0] err_code;
  logic [63:0] cache_desc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  segdesc_validator dut_i (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .role(role), .sel(sel),
    .desc_lo(desc_lo), .desc_hi(desc_hi), .fetch_ok(fetch_ok), .code_rpl(code_rpl),
    .res_valid(res_valid), .verdict(verdict), .err_code(err_code), .cache_desc(cache_desc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Model built from the requirements; tag names the deciding requirement
  function automatic logic [2:0] model(input logic [1:0] r, input logic [15:0] s,
      input logic [31:0] hi, input logic fok, input logic [1:0] crpl, output string tag);
    logic [3:0] t;
    logic [1:0] d, rp;
    logic sb, pb;
    t = hi[11:8]; sb = hi[12]; d = hi[14:13]; pb = hi[15]; rp = s[1:0];
    if (s[15:2] == 14'd0) begin tag = "R2"; return r[1] ? 3'd1 : 3'd2; end
    if (!fok) begin tag = "R3/R10"; return 3'd2; end
    if (r == 2'd0) begin
      if (!(sb && !t[3] && t[1])) begin tag = "R4/R10"; return 3'd2; end
      if (d != crpl || d != rp) begin tag = "R5/R10"; return 3'd2; end
      if (!pb) begin tag = "R5"; return 3'd4; end
      tag = "R10"; return 3'd0;
    end
    if (r == 2'd1) begin
      if (!(sb && t[3])) begin tag = "R6/R10"; return 3'd2; end
      if (t[2] ? (d > rp) : (d != rp)) begin tag = "R6/R10"; return 3'd2; end
      if (!pb) begin tag = "R9"; return 3'd3; end
      tag = "R10"; return 3'd0;
    end
    if (!(sb && (!t[3] || t[1]))) begin tag = "R7/R10"; return 3'd2; end
    if ((!t[3] || !t[2]) && (rp > d || crpl > d)) begin tag = "R8/R10"; return 3'd2; end
    if (!pb) begin tag = "R9"; return 3'd3; end
    tag = "R10"; return 3'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] ev;
    string tg;
    logic [2:0] held_v;
    logic [15:0] held_e;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset res_valid", {63'd0, res_valid}, 64'd0);
    check("R1 reset verdict", {61'd0, verdict}, 64'd0);
    check("R1 reset err_code", {48'd0, err_code}, 64'd0);
    check("R1 reset cache_desc", cache_desc, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int r = 0; r < 4; r++)
      for (int nl = 0; nl < 2; nl++)
        for (int rp = 0; rp < 4; rp++)
          for (int cr = 0; cr < 4; cr++)
            for (int fk = 0; fk < 2; fk++)
              for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                chk_valid = 1'b1;
                role      = 2'(r);
                sel       = nl ? {14'd0, 2'(rp)} : {6'h2C, 8'(b), 2'(rp)};
                desc_hi   = {8'(b) ^ 8'hA5, 8'h4F, 8'(b), 8'h1D};
                desc_lo   = {8'(b), 8'h3C, ~8'(b), 8'h77};
                fetch_ok  = 1'(fk);
                code_rpl  = 2'(cr);
                ev = model(role, sel, desc_hi, fetch_ok, code_rpl, tg);
                @(posedge clk);
                #1;
                check({tg, " verdict"}, {61'd0, verdict}, {61'd0, ev});
                check("R11 err_code", {48'd0, err_code},
                      {48'd0, (ev >= 3'd2) ? {sel[15:2], 2'b00} : 16'd0});
                check("R12 cache_desc", cache_desc,
                      (ev == 3'd0) ? {desc_hi, desc_lo} : 64'd0);
                if (b == 0) check("R1 res_valid high", {63'd0, res_valid}, 64'd1);
              end

    held_v = verdict;
    held_e = err_code;
    @(negedge clk);
    chk_valid = 1'b0;
    sel = 16'h0000;
    role = 2'd2;
    @(posedge clk);
    #1;
    check("R1 idle res_valid", {63'd0, res_valid}, 64'd0);
    check("R1 idle verdict held", {61'd0, verdict}, {61'd0, held_v});
    check("R1 idle err held", {48'd0, err_code}, {48'd0, held_e});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule